// File: doc/BRIEF.md
# Addressed Serial Display Data Receiver

This block takes display data from a slow synchronous serial link of two or three wires: a data clock, a data line and an optional enable line. A fast system clock oversamples all three lines. The block frames each transfer between start and stop conditions and accepts data only after a fixed 8-bit device address. The data is collected in a 128-bit shift register. A completed block is then copied into a 128-bit display latch. The latch drives the segment multiplexer, which shows the word as four 32-bit groups, one group per backplane slot.

The copy into the latch happens in one of two ways. With the enable line held high, the copy is automatic after every 128 data bits. With the enable line held low, the automatic copy is suppressed, and the latch loads only on a rising edge of enable while the data clock is high. The sender may leave the channel open after a block. In that case one clock edge is skipped, and reception goes on with the next block.

Top module: `disp_serial_rx`

## Requirements
- R1: Both lines idle high. A fall of the data line while the data clock is high is a start condition: it opens an address phase and restarts the bit count at zero. The shift register keeps its contents.
- R2: The 8 bits after a start form the address, most significant bit first. Only the value 0x7E (binary 01111110) selects the receiver. Any other value makes the receiver ignore all clock edges until the next start.
- R3: After a matching address, each rising data-clock edge shifts in one data bit, most significant first. The first bit of a block ends in bit 127 of the latched word and the last bit in bit 0.
- R4: With enable high, the shift register is copied into the display latch when the 128th bit of a block is received. The update strobe is high for exactly one system clock in the cycle the new word appears.
- R5: With enable low, a completed block does not change the latch. A rising edge of enable while the data clock is high copies the last 128 received bits into the latch and raises the strobe.
- R6: A rising edge of enable while the data clock is low has no effect on the latch or the strobe.
- R7: If neither a stop nor a start follows the 128th bit, the next rising clock edge is ignored. The 128 edges after it form a new block.
- R8: A rise of the data line while the data clock is high is a stop condition. It ends the transfer at any point. Clock edges after a stop are ignored until a start, and a partial block is never latched.
- R9: A synchronous active-high reset clears the latch to zero, holds the strobe low and returns the receiver to idle.
- R10: The latched word changes only in a cycle where the update strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| rst | input | 1 | Synchronous active-high reset |
| dclk_i | input | 1 | Serial data clock, idle high |
| dat_i | input | 1 | Serial data line, idle high |
| en_i | input | 1 | Latch enable: high for automatic latching, low for a manual pulse |
| disp_word_o | output | 128 | Latched display word, four 32-bit backplane groups, group 0 in the top bits |
| disp_upd_o | output | 1 | One-cycle strobe when the latch is written |

## Verification
The assertions assume that the link is much slower than the system clock. Each line must hold a level for several system cycles, and the data line may change only while the data clock is low, except when it forms a start or stop condition. The stimulus keeps to this rule. Every bus phase lasts at least three system clocks. Data is set up in the middle of the clock-low phase. Start and stop conditions are made with the clock settled high. Enable edges are made only after the serial clock has settled at the level that phase of the test needs.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_ADDR = 2'd1,
    RX_DATA = 2'd2,
    RX_SKIP = 2'd3
  } rx_state_e;
endpackage

// File: rtl/dsr_line_sync.sv
// Synchronizes the link lines and derives the start, stop, clock-rise and enable-pulse events.
module dsr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dclk_i,
  input  logic dat_i,
  input  logic en_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic bit_o,
  output logic en_lvl_o,
  output logic en_rise_o
);
  localparam int NLINES = 3;
  localparam int CUR = STAGES - 1;
  localparam int PRV = STAGES;

  logic [NLINES-1:0] raw;
  logic [STAGES:0]   chain [NLINES];

  assign raw = {en_i, dat_i, dclk_i};

  // Chains reset to the idle-high level, so a line held high produces no edge.
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= '1;
      else     chain[g] <= {chain[g][STAGES-1:0], raw[g]};
    end
  end

  logic c_cur, c_prv, d_cur, d_prv, e_cur, e_prv;
  assign c_cur = chain[0][CUR];
  assign c_prv = chain[0][PRV];
  assign d_cur = chain[1][CUR];
  assign d_prv = chain[1][PRV];
  assign e_cur = chain[2][CUR];
  assign e_prv = chain[2][PRV];

  assign start_o   = c_cur & c_prv & d_prv & ~d_cur;
  assign stop_o    = c_cur & c_prv & ~d_prv & d_cur;
  assign rise_o    = c_cur & ~c_prv;
  assign bit_o     = d_cur;
  assign en_lvl_o  = e_cur;
  assign en_rise_o = e_cur & ~e_prv & c_cur;

  p_cond_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(start_o && (stop_o || rise_o)));
endmodule

// File: rtl/dsr_shift_rx.sv
// Framing state machine: address check, bit counting and the data shift register.
module dsr_shift_rx
  import dsr_pkg::*;
#(
  parameter int DATA_BITS = 128,
  parameter int ADDR_BITS = 8,
  parameter logic [ADDR_BITS-1:0] DEV_ADDR = 'h7E
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 rise_i,
  input  logic                 bit_i,
  output logic [DATA_BITS-1:0] shreg_o,
  output logic                 blk_done_o
);
  localparam int MAXB  = (DATA_BITS > ADDR_BITS) ? DATA_BITS : ADDR_BITS;
  localparam int CNT_W = $clog2(MAXB);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_BITS - 1);

  rx_state_e             state_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [ADDR_BITS-1:0]  addr_q;
  logic [ADDR_BITS-1:0]  addr_nx;
  logic [DATA_BITS-1:0]  sr_q;
  logic                  gap_q;
  logic                  done_q;

  assign addr_nx = {addr_q[ADDR_BITS-2:0], bit_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      sr_q    <= '0;
      gap_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        state_q <= RX_ADDR;
        cnt_q   <= '0;
        addr_q  <= '0;
        gap_q   <= 1'b0;
      end else if (stop_i) begin
        state_q <= RX_IDLE;
        gap_q   <= 1'b0;
      end else if (rise_i) begin
        case (state_q)
          RX_ADDR: begin
            addr_q <= addr_nx;
            if (cnt_q == ADDR_LAST) begin
              cnt_q   <= '0;
              state_q <= (addr_nx == DEV_ADDR) ? RX_DATA : RX_SKIP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (gap_q) begin
              gap_q <= 1'b0;
            end else begin
              sr_q <= {sr_q[DATA_BITS-2:0], bit_i};
              if (cnt_q == DATA_LAST) begin
                cnt_q  <= '0;
                gap_q  <= 1'b1;
                done_q <= 1'b1;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign shreg_o    = sr_q;
  assign blk_done_o = done_q;

  p_start_addr_r1: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (state_q == RX_ADDR && cnt_q == '0));
  p_skip_sticks_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_SKIP && !start_i) |=> state_q != RX_DATA);
  p_gap_edge_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == RX_DATA && gap_q && rise_i && !start_i && !stop_i)
      |=> ($stable(sr_q) && !gap_q && !done_q));
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !start_i) |=> (state_q == RX_IDLE && !done_q));
endmodule

// File: rtl/dsr_disp_latch.sv
// Display latch: loads on a completed block with enable high, or on an enable pulse.
module dsr_disp_latch #(
  parameter int DATA_BITS = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 blk_done_i,
  input  logic                 en_lvl_i,
  input  logic                 en_rise_i,
  input  logic [DATA_BITS-1:0] shreg_i,
  output logic [DATA_BITS-1:0] word_o,
  output logic                 upd_o
);
  logic load;
  assign load = (blk_done_i & en_lvl_i) | en_rise_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= load;
      if (load) word_o <= shreg_i;
    end
  end

  p_auto_latch_r4: assert property (@(posedge clk) disable iff (rst)
    (blk_done_i && en_lvl_i) |=> (upd_o && word_o == $past(shreg_i)));
  p_no_auto_r5: assert property (@(posedge clk) disable iff (rst)
    (blk_done_i && !en_lvl_i && !en_rise_i) |=> !upd_o);
  p_word_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !upd_o |-> $stable(word_o));
endmodule

// File: rtl/disp_serial_rx.sv
module disp_serial_rx #(
  parameter int DATA_BITS   = 128,
  parameter int ADDR_BITS   = 8,
  parameter logic [ADDR_BITS-1:0] DEV_ADDR = 'h7E,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dclk_i,
  input  logic                 dat_i,
  input  logic                 en_i,
  output logic [DATA_BITS-1:0] disp_word_o,
  output logic                 disp_upd_o
);
  logic start_w, stop_w, rise_w, bit_w, en_lvl_w, en_rise_w;
  logic blk_done_w;
  logic [DATA_BITS-1:0] shreg_w;

  dsr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .dclk_i   (dclk_i),
    .dat_i    (dat_i),
    .en_i     (en_i),
    .start_o  (start_w),
    .stop_o   (stop_w),
    .rise_o   (rise_w),
    .bit_o    (bit_w),
    .en_lvl_o (en_lvl_w),
    .en_rise_o(en_rise_w)
  );

  dsr_shift_rx #(
    .DATA_BITS(DATA_BITS),
    .ADDR_BITS(ADDR_BITS),
    .DEV_ADDR (DEV_ADDR)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_w),
    .stop_i    (stop_w),
    .rise_i    (rise_w),
    .bit_i     (bit_w),
    .shreg_o   (shreg_w),
    .blk_done_o(blk_done_w)
  );

  dsr_disp_latch #(.DATA_BITS(DATA_BITS)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .blk_done_i(blk_done_w),
    .en_lvl_i  (en_lvl_w),
    .en_rise_i (en_rise_w),
    .shreg_i   (shreg_w),
    .word_o    (disp_word_o),
    .upd_o     (disp_upd_o)
  );

  p_reset_state_r9: assert property (@(posedge clk)
    $past(rst) |-> (disp_word_o == '0 && !disp_upd_o));
endmodule

// File: tb/tb_disp_serial_rx.sv
`timescale 1ns/1ps
module tb_disp_serial_rx;
  localparam int W = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dclk = 1'b1;
  logic dat  = 1'b1;
  logic en   = 1'b1;
  logic [W-1:0] word;
  logic upd;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [W-1:0] expq [$];

  always #10 clk = ~clk;

  disp_serial_rx dut (
    .clk(clk), .rst(rst), .dclk_i(dclk), .dat_i(dat), .en_i(en),
    .disp_word_o(word), .disp_upd_o(upd)
  );

  // Monitor: every strobe pops one expected word (R4, R5, R10).
  always @(negedge clk) begin
    if (!rst && upd) begin
      tests++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R10: unexpected update, got %h expected no update", word);
      end else begin
        logic [W-1:0] e;
        e = expq.pop_front();
        if (word !== e) begin
          fails++;
          $display("FAIL R3/R4: latched %h expected %h", word, e);
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bit_out(input logic b);
    dclk = 1'b0; wait_clk(3);
    dat  = b;    wait_clk(3);
    dclk = 1'b1; wait_clk(4);
  endtask

  task automatic start_c();
    dclk = 1'b0; wait_clk(3);
    dat  = 1'b1; wait_clk(3);
    dclk = 1'b1; wait_clk(4);
    dat  = 1'b0; wait_clk(4);
  endtask

  task automatic stop_c();
    dclk = 1'b0; wait_clk(3);
    dat  = 1'b0; wait_clk(3);
    dclk = 1'b1; wait_clk(4);
    dat  = 1'b1; wait_clk(4);
  endtask

  task automatic send_addr(input logic [7:0] a);
    for (int i = 7; i >= 0; i--) bit_out(a[i]);
  endtask

  task automatic send_block(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) bit_out(w[i]);
  endtask

  task automatic push_exp(input logic [W-1:0] w);
    expq.push_back(w);
  endtask

  task automatic chk_drained(input string tag);
    wait_clk(20);
    tests++;
    if (expq.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d updates missing, expected 0", tag, expq.size());
      expq.delete();
    end
  endtask

  task automatic chk_word(input string tag, input logic [W-1:0] e);
    @(negedge clk);
    tests++;
    if (word !== e) begin
      fails++;
      $display("FAIL %s: word %h expected %h", tag, word, e);
    end
  endtask

  initial begin
    logic [W-1:0] pa, pb, pc, pd, pe, pz;
    pa = {32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210};
    pb = ~pa;
    pc = pa ^ {4{32'h5A5A5A5A}};
    pd = {32'hDEADBEEF, 32'h00000001, 32'h80000000, 32'hC0FFEE11};
    pe = {4{32'h0F0F3C3C}};
    pz = {W{1'b1}};

    wait_clk(5);
    rst = 1'b0;
    // R9: reset state
    chk_word("R9", '0);
    tests++;
    if (upd !== 1'b0) begin
      fails++;
      $display("FAIL R9: strobe %b expected 0", upd);
    end

    // R1 R2 R3 R4: addressed block, automatic latch
    push_exp(pa);
    start_c(); send_addr(8'h7E); send_block(pa); stop_c();
    chk_drained("R4");
    chk_word("R3", pa);

    // R2: wrong address is ignored
    start_c(); send_addr(8'h7C); send_block(pz); stop_c();
    chk_drained("R2");
    chk_word("R2", pa);

    // R7: open channel, 129th edge skipped
    push_exp(pb); push_exp(pc);
    start_c(); send_addr(8'h7E); send_block(pb);
    bit_out(~pc[W-1]);
    send_block(pc); stop_c();
    chk_drained("R7");
    chk_word("R7", pc);

    // R8: stop aborts a partial block; R1: restart counts from zero
    start_c(); send_addr(8'h7E);
    for (int i = 0; i < 50; i++) bit_out(1'b1);
    stop_c();
    for (int i = 0; i < 10; i++) bit_out(1'b0);
    chk_drained("R8");
    chk_word("R8", pc);
    push_exp(pe);
    start_c(); send_addr(8'h7E); send_block(pe); stop_c();
    chk_drained("R1");

    // R5: enable low suppresses automatic latch
    en = 1'b0; wait_clk(6);
    start_c(); send_addr(8'h7E); send_block(pd); stop_c();
    chk_drained("R5");
    chk_word("R5", pe);
    push_exp(pd);
    en = 1'b1; wait_clk(6); en = 1'b0;
    chk_drained("R5");
    chk_word("R5", pd);

    // R6: enable pulse with clock low is ignored
    dclk = 1'b0; wait_clk(6);
    en = 1'b1; wait_clk(6); en = 1'b0; wait_clk(6);
    dclk = 1'b1;
    chk_drained("R6");
    chk_word("R6", pd);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule